// File: doc/BRIEF.md
# Twelve-Channel Doorbell Mailbox

This block carries messages between an application processor and an embedded power-management controller. The processor side reaches it over a simple 32-bit register bus. The low part of the address space is a shared data window. Every channel owns a fixed outgoing region there, which the processor fills, and a fixed incoming region, which the controller fills. A control window starting at `CTL_BASE` holds one bit per channel in each of its registers: outgoing status, doorbell, incoming clear and incoming status.

To send, the processor writes the channel's outgoing words and then rings that channel's doorbell bit. The outgoing status bit stays at 1 until the controller takes the message. Completion of a send raises no interrupt, so software must poll that bit.

The controller side is a separate port. It can read the outgoing region by word index and consume a channel, which clears the channel's outgoing status. It can also post a whole response in one cycle. Posting fills the channel's incoming region and sets the channel's incoming status bit. The single interrupt line is the OR of the incoming status bits. The processor drops a channel's bit by writing that bit to the clear register.

Top module: `doorbell_mbox`

## Requirements
- R1: Outgoing regions start at these byte offsets, with these lengths in words: ch0 0x00/4, ch1 0x10/8, ch2 0x30/3, ch3 0x3C/6, ch4 0x54/9, ch5 0x78/4, ch6 0x88/6, ch7 0xA0/6, ch8 0xB8/1, ch9 0xBC/4, ch10 0xCC/4, ch11 0xDC/1. A word written at byte offset A in 0x000..0x0DF is read on the remote port at word index A/4, one cycle after the index is presented.
- R2: Incoming regions start at these byte offsets, with these lengths in words: ch0 0xE0/4, ch1 0xF0/8, ch2 0x110/1, ch3 0x114/1, ch4 0x118/1, ch5 0x11C/4, ch6 0x12C/1, ch7 0x130/6, ch8 0x148/4, ch9 0x158/1, ch10 0x15C/4, ch11 0x16C/1. A post on channel n stores bits [32i+31:32i] of the post data as word i of that region. It does not touch any other channel's region.
- R3: Writing to the doorbell (CTL_BASE+0x04) sets the outgoing status bit n of every channel n whose data bit is 1. Bits written as 0 leave their channels unchanged. Outgoing status is read at CTL_BASE+0x00 (bit n = channel n) and is driven on `rmt_tx_pending`.
- R4: A consume on channel n clears its outgoing status bit. If a doorbell for the same channel arrives in the same cycle, the bit stays set.
- R5: A post sets the channel's incoming status bit (CTL_BASE+0x78, bit n = channel n). `irq` is high from the next cycle on, as long as any incoming status bit is set.
- R6: Writing to the clear register (CTL_BASE+0x74) clears the incoming status bits written as 1. A post to the same channel in the same cycle wins.
- R7: Doorbells and consumes never change `irq`.
- R8: While `clk_en` is low, bus writes have no effect and bus reads return zero.
- R9: These reads return zero: misaligned addresses, data offsets at or above 0x170, and control offsets other than 0x00 and 0x78. Bus writes to the status registers and to the incoming regions have no effect.
- R10: Read data appears on `bus_rdata` one cycle after the read is accepted. A status read returns the value before any update made in the same cycle.
- R11: A remote channel index above 11 makes consume and post do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Controller clock enable; gates bus accesses |
| bus_valid | input | 1 | Bus access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| irq | output | 1 | Level interrupt: a response is pending |
| rmt_consume | input | 1 | Remote takes the outgoing message of `rmt_chan` |
| rmt_post | input | 1 | Remote posts a response on `rmt_chan` |
| rmt_chan | input | 4 | Remote channel index |
| rmt_post_data | input | 256 | Response words, word i in bits [32i+31:32i] |
| rmt_rd_word | input | 6 | Outgoing-region word index to read |
| rmt_rd_data | output | 32 | Outgoing word, one cycle after the index |
| rmt_tx_pending | output | 12 | Outgoing status bits |

## Verification
A wrong status bit shows up at the ports within one cycle: on `rmt_tx_pending` right away for outgoing status, and on `irq` and the next status read for incoming status. A wrong channel-map entry shows up as data read at the wrong offset, or as a neighbour's region being overwritten. The bench checks for this by reading the words next to each region it posts to. Same-cycle collisions of doorbell with consume and of post with clear are driven on purpose, because a wrong priority there silently loses a message.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NCH      = 12;
  localparam int DW       = 32;
  localparam int MAX_RX_W = 8;

  // Words per channel; the order fixes the packed byte offsets.
  localparam int TX_LEN_W [NCH] = '{4, 8, 3, 6, 9, 4, 6, 6, 1, 4, 4, 1};
  localparam int RX_LEN_W [NCH] = '{4, 8, 1, 1, 1, 4, 1, 6, 4, 1, 4, 1};

  function automatic int tx_base(int ch);
    int s = 0;
    for (int i = 0; i < ch; i++) s += TX_LEN_W[i];
    return s;
  endfunction

  function automatic int rx_base(int ch);
    int s = 0;
    for (int i = 0; i < ch; i++) s += RX_LEN_W[i];
    return s;
  endfunction

  function automatic int rx_owner(int k);
    int o = 0;
    for (int c = 0; c < NCH; c++)
      if (k >= rx_base(c) && k < rx_base(c + 1)) o = c;
    return o;
  endfunction

  localparam int TX_WORDS = tx_base(NCH);
  localparam int RX_WORDS = rx_base(NCH);

  // Control window offsets (relative to the control base)
  localparam int OFS_TX_STS = 'h00;
  localparam int OFS_RING   = 'h04;
  localparam int OFS_RX_CLR = 'h74;
  localparam int OFS_RX_STS = 'h78;
  localparam int CTL_SPAN   = 'h80;

  typedef enum logic [1:0] {RD_NONE, RD_TX, RD_RX, RD_CTL} rd_sel_e;
endpackage

// File: rtl/mbx_ctl_regs.sv
module mbx_ctl_regs #(
  parameter int NCH = 12,
  parameter int CHW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ring_we,
  input  logic           clr_we,
  input  logic [NCH-1:0] wmask,
  input  logic           consume,
  input  logic           post,
  input  logic [CHW-1:0] chan,
  output logic [NCH-1:0] tx_sts,
  output logic [NCH-1:0] rx_sts,
  output logic           irq
);
  logic [NCH-1:0] take_v, post_v, tx_nxt, rx_nxt;

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign take_v[i] = consume && (chan == CHW'(i));
    assign post_v[i] = post && (chan == CHW'(i));
  end

  always_comb begin
    tx_nxt = (tx_sts & ~take_v) | (ring_we ? wmask : '0);
    rx_nxt = (rx_sts & ~(clr_we ? wmask : '0)) | post_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sts <= '0;
      rx_sts <= '0;
      irq    <= 1'b0;
    end else begin
      tx_sts <= tx_nxt;
      rx_sts <= rx_nxt;
      irq    <= |rx_nxt;
    end
  end
endmodule

// File: rtl/mbx_data_win.sv
module mbx_data_win
  import mbx_pkg::*;
#(
  parameter int TXA = 6,
  parameter int RXA = 6,
  parameter int CHW = 4,
  parameter int PW  = MAX_RX_W * DW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tx_we,
  input  logic [TXA-1:0] tx_widx,
  input  logic [DW-1:0]  tx_wdata,
  input  logic [TXA-1:0] host_tx_ridx,
  input  logic [RXA-1:0] host_rx_ridx,
  input  logic           post,
  input  logic [CHW-1:0] chan,
  input  logic [PW-1:0]  post_data,
  input  logic [TXA-1:0] rmt_ridx,
  output logic [DW-1:0]  host_tx_rdata,
  output logic [DW-1:0]  host_rx_rdata,
  output logic [DW-1:0]  rmt_rdata
);
  // Outgoing store: one write port, two registered read ports.
  logic [DW-1:0] tx_mem [TX_WORDS];

  always_ff @(posedge clk) begin
    if (tx_we) tx_mem[tx_widx] <= tx_wdata;
    host_tx_rdata <= tx_mem[host_tx_ridx];
    rmt_rdata     <= tx_mem[rmt_ridx];
  end

  // Incoming store: a whole channel region is written in one cycle.
  logic [DW-1:0] rx_q [RX_WORDS];

  for (genvar k = 0; k < RX_WORDS; k++) begin : g_rx
    localparam int OWN = rx_owner(k);
    localparam int IDX = k - rx_base(OWN);
    always_ff @(posedge clk) begin
      if (rst)
        rx_q[k] <= '0;
      else if (post && chan == CHW'(OWN))
        rx_q[k] <= post_data[IDX*DW +: DW];
    end
  end

  always_ff @(posedge clk) host_rx_rdata <= rx_q[host_rx_ridx];
endmodule

// File: rtl/doorbell_mbox.sv
module doorbell_mbox
  import mbx_pkg::*;
#(
  parameter int AW       = 12,
  parameter int CTL_BASE = 'h200
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clk_en,
  input  logic                   bus_valid,
  input  logic                   bus_write,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  output logic                   irq,
  input  logic                   rmt_consume,
  input  logic                   rmt_post,
  input  logic [3:0]             rmt_chan,
  input  logic [MAX_RX_W*DW-1:0] rmt_post_data,
  input  logic [5:0]             rmt_rd_word,
  output logic [DW-1:0]          rmt_rd_data,
  output logic [NCH-1:0]         rmt_tx_pending
);
  localparam int TXA      = $clog2(TX_WORDS);
  localparam int RXA      = $clog2(RX_WORDS);
  localparam int TX_BYTES = TX_WORDS * 4;
  localparam int RX_END   = TX_BYTES + RX_WORDS * 4;

  logic          acc, aligned, in_tx, in_rx, in_ctl;
  logic [AW-1:0] coff;
  logic [AW-3:0] wa, rx_wa;
  logic          ring_we, clr_we, tx_we, rd;
  logic [NCH-1:0] tx_sts, rx_sts;
  logic [DW-1:0] tx_rd, rx_rd;
  rd_sel_e       sel_q;
  logic [NCH-1:0] ctl_q;

  always_comb begin
    aligned = (bus_addr[1:0] == 2'b00);
    acc     = bus_valid && clk_en && aligned;
    wa      = bus_addr[AW-1:2];
    rx_wa   = wa - (AW-2)'(TX_WORDS);
    coff    = bus_addr - AW'(CTL_BASE);
    in_tx   = int'(bus_addr) < TX_BYTES;
    in_rx   = int'(bus_addr) >= TX_BYTES && int'(bus_addr) < RX_END;
    in_ctl  = int'(bus_addr) >= CTL_BASE && int'(bus_addr) < CTL_BASE + CTL_SPAN;
    ring_we = acc && bus_write && in_ctl && coff == AW'(OFS_RING);
    clr_we  = acc && bus_write && in_ctl && coff == AW'(OFS_RX_CLR);
    tx_we   = acc && bus_write && in_tx;
    rd      = acc && !bus_write;
  end

  mbx_ctl_regs #(.NCH(NCH), .CHW(4)) u_ctl (
    .clk(clk), .rst(rst), .ring_we(ring_we), .clr_we(clr_we),
    .wmask(bus_wdata[NCH-1:0]), .consume(rmt_consume), .post(rmt_post),
    .chan(rmt_chan), .tx_sts(tx_sts), .rx_sts(rx_sts), .irq(irq)
  );

  mbx_data_win #(.TXA(TXA), .RXA(RXA), .CHW(4)) u_win (
    .clk(clk), .rst(rst), .tx_we(tx_we), .tx_widx(wa[TXA-1:0]),
    .tx_wdata(bus_wdata), .host_tx_ridx(wa[TXA-1:0]),
    .host_rx_ridx(rx_wa[RXA-1:0]), .post(rmt_post), .chan(rmt_chan),
    .post_data(rmt_post_data), .rmt_ridx(rmt_rd_word),
    .host_tx_rdata(tx_rd), .host_rx_rdata(rx_rd), .rmt_rdata(rmt_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= RD_NONE;
      ctl_q <= '0;
    end else begin
      sel_q <= RD_NONE;
      ctl_q <= (coff == AW'(OFS_TX_STS)) ? tx_sts : rx_sts;
      if (rd) begin
        if (in_tx) sel_q <= RD_TX;
        else if (in_rx) sel_q <= RD_RX;
        else if (in_ctl && (coff == AW'(OFS_TX_STS) || coff == AW'(OFS_RX_STS)))
          sel_q <= RD_CTL;
      end
    end
  end

  always_comb begin
    unique case (sel_q)
      RD_TX:   bus_rdata = tx_rd;
      RD_RX:   bus_rdata = rx_rd;
      RD_CTL:  bus_rdata = DW'(ctl_q);
      default: bus_rdata = '0;
    endcase
  end

  assign rmt_tx_pending = tx_sts;
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk (
  input logic        clk,
  input logic        rst,
  input logic        clk_en,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        irq,
  input logic        rmt_consume,
  input logic        rmt_post,
  input logic [3:0]  rmt_chan,
  input logic [11:0] rmt_tx_pending
);
  logic ring_w, clr_w;
  assign ring_w = clk_en && bus_valid && bus_write && bus_addr == 12'h204;
  assign clr_w  = clk_en && bus_valid && bus_write && bus_addr == 12'h274;

  // R3
  ring_set_chk: assert property (@(posedge clk) disable iff (rst)
    ring_w |=> ((rmt_tx_pending & $past(bus_wdata[11:0])) == $past(bus_wdata[11:0])));

  // R4
  consume_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (rmt_consume && rmt_chan < 4'd12 && !(ring_w && bus_wdata[rmt_chan]))
      |=> !rmt_tx_pending[$past(rmt_chan)]);

  // R5
  post_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (rmt_post && rmt_chan < 4'd12) |=> irq);

  // R6
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(clr_w));

  // R8
  gated_rd_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> bus_rdata == 32'h0);

  // R11
  bad_chan_chk: assert property (@(posedge clk) disable iff (rst)
    (rmt_consume && rmt_chan > 4'd11 && !ring_w) |=> $stable(rmt_tx_pending));
endmodule

bind doorbell_mbox mbx_chk chk_i (
  .clk(clk), .rst(rst), .clk_en(clk_en), .bus_valid(bus_valid),
  .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq(irq), .rmt_consume(rmt_consume),
  .rmt_post(rmt_post), .rmt_chan(rmt_chan), .rmt_tx_pending(rmt_tx_pending)
);

// File: tb/doorbell_mbox_tb.sv
module doorbell_mbox_tb_top;
  logic clk = 0, rst = 1, clk_en = 1;
  logic bus_valid = 0, bus_write = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, rmt_rd_data;
  logic irq, rmt_consume = 0, rmt_post = 0;
  logic [3:0] rmt_chan = 0;
  logic [255:0] rmt_post_data = 0;
  logic [5:0] rmt_rd_word = 0;
  logic [11:0] rmt_tx_pending;

  int vectors = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q [$];
  string tag_q [$];
  logic rd_fire = 0;

  always #4 clk = ~clk;

  doorbell_mbox dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: a read accepted at a rising edge is compared at the next falling edge (R10)
  always @(posedge clk) rd_fire <= bus_valid && !bus_write;
  always @(negedge clk) if (rd_fire) begin
    logic [31:0] e; string t;
    e = exp_q.pop_front(); t = tag_q.pop_front();
    chk({t, " R10"}, bus_rdata, e);
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] e, string t);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_valid = 0;
  endtask

  task automatic rrd(int w, logic [31:0] e, string t);
    rmt_rd_word = 6'(w);
    @(negedge clk); chk(t, rmt_rd_data, e);
  endtask

  function automatic logic [255:0] pat(int ch);
    logic [255:0] p;
    for (int i = 0; i < 8; i++) p[32*i +: 32] = 32'hA000_0000 | (ch << 8) | i;
    return p;
  endfunction

  task automatic post(int ch);
    rmt_chan = 4'(ch); rmt_post_data = pat(ch); rmt_post = 1;
    @(negedge clk); rmt_post = 0;
  endtask

  task automatic consume(int ch);
    rmt_chan = 4'(ch); rmt_consume = 1;
    @(negedge clk); rmt_consume = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R5 reset irq", 32'(irq), 0);
    chk("R3 reset pending", 32'(rmt_tx_pending), 0);
    rd(12'h200, 0, "R3 reset tx sts");
    rd(12'h278, 0, "R5 reset rx sts");

    // R1: outgoing regions
    for (int i = 0; i < 4; i++) wr(12'(4*i), 32'h1000 + i);
    for (int i = 0; i < 9; i++) wr(12'h054 + 12'(4*i), 32'h4400 + i);
    wr(12'h0DC, 32'hBBBB_0011);
    rrd(0, 32'h1000, "R1 ch0 w0");
    rrd(3, 32'h1003, "R1 ch0 w3");
    rrd(21, 32'h4400, "R1 ch4 w0");
    rrd(29, 32'h4408, "R1 ch4 w8");
    rrd(55, 32'hBBBB_0011, "R1 ch11");
    rd(12'h058, 32'h4401, "R1 host readback ch4 w1");

    // R3 and R7
    wr(12'h204, 32'h805);
    chk("R3 ring", 32'(rmt_tx_pending), 32'h805);
    chk("R7 no irq on ring", 32'(irq), 0);
    wr(12'h204, 32'h002);
    chk("R3 zeros keep", 32'(rmt_tx_pending), 32'h807);
    rd(12'h200, 32'h807, "R3 tx sts read");

    // R4
    consume(2);
    chk("R4 consume", 32'(rmt_tx_pending), 32'h803);
    chk("R7 no irq on consume", 32'(irq), 0);
    rmt_chan = 0; rmt_consume = 1;
    wr(12'h204, 32'h001);
    rmt_consume = 0;
    chk("R4 ring wins", 32'(rmt_tx_pending), 32'h803);
    consume(13);
    chk("R11 bad consume", 32'(rmt_tx_pending), 32'h803);

    // R5, R2
    post(2);
    chk("R5 irq", 32'(irq), 1);
    rd(12'h278, 32'h004, "R5 rx sts");
    rd(12'h110, 32'hA000_0200, "R2 ch2 w0");
    rd(12'h114, 0, "R2 ch3 untouched");
    post(1);
    rd(12'h0F0, 32'hA000_0100, "R2 ch1 w0");
    rd(12'h10C, 32'hA000_0107, "R2 ch1 w7");
    rd(12'h0EC, 0, "R2 ch0 untouched");
    post(14);
    rd(12'h278, 32'h006, "R11 bad post");

    // R6
    wr(12'h274, 32'h002);
    rd(12'h278, 32'h004, "R6 clear one");
    chk("R6 irq held", 32'(irq), 1);
    rmt_chan = 5; rmt_post_data = pat(5); rmt_post = 1;
    wr(12'h274, 32'h020);
    rmt_post = 0;
    rd(12'h278, 32'h024, "R6 post wins");
    wr(12'h274, 32'hFFF);
    chk("R6 irq drop", 32'(irq), 0);

    // R8
    clk_en = 0;
    wr(12'h204, 32'h010);
    chk("R8 ring ignored", 32'(rmt_tx_pending), 32'h803);
    wr(12'h000, 32'hDEAD);
    rd(12'h200, 0, "R8 gated read");
    clk_en = 1;
    rrd(0, 32'h1000, "R8 data kept");

    // R9
    rd(12'h170, 0, "R9 past data");
    rd(12'h208, 0, "R9 ctl hole");
    rd(12'h112, 0, "R9 misaligned");
    wr(12'h200, 32'hFFF);
    chk("R9 sts write", 32'(rmt_tx_pending), 32'h803);
    wr(12'h110, 32'h5555);
    rd(12'h110, 32'hA000_0200, "R9 rx write ignored");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule